// File: doc/BRIEF.md
# Calendar Alarm Match and Interrupt Unit

This block watches a running BCD calendar (seconds, minutes, hours, date, month, day of week) and compares it against a number of independent alarm register sets. The default is two alarm sets. Every field of every alarm has its own participation bit, and only fields whose bit is set take part in the comparison. A comparison is made only in the cycle that carries the once-per-second tick. This means a match that is held cannot register twice within the same second.

A match always sets that alarm's status flag. The flag stays set until the host issues a status-read strobe. The active-low interrupt line reacts only to alarms whose interrupt enable is set.

A single mode bit selects one of two interrupt styles:
- **Latched (single-shot):** the line stays low while an enabled flag is pending, so each match gives one interrupt that the host acknowledges by reading status.
- **Pulsed (repeating):** every enabled match drives the line low for a fixed number of prescaler ticks and then releases it. This happens on each later match of the enabled fields.

The calendar counter, the oscillator and any frequency output sit outside this block.

Top module: `alm_match_irq`

## Requirements
- R1: In a cycle with `sec_tick` high, alarm a matches when every field f whose enable bit `alm_fen[a*6+f]` is set has `alm_val[(a*6+f)*8 +: 8]` equal to `cur_time[f*8 +: 8]`. The field order is f=0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, and all 8 bits of a field are compared.
- R2: A field whose enable bit is clear has no effect on the match, whatever its alarm and calendar values.
- R3: An alarm whose six field enable bits are all clear never matches.
- R4: Without `sec_tick`, no status flag becomes set, even while the enabled fields are equal.
- R5: A match of alarm a sets `stat_flags[a]` (bit 0 for alarm 0, bit 1 for alarm 1), visible in the cycle after the tick, whatever `alm_irq_en` holds. The alarms set their flags independently.
- R6: A status flag stays set until `stat_rd` is high at a clock edge, which clears all flags. If a match arrives at that same edge, that alarm's flag is set rather than cleared.
- R7: An alarm whose `alm_irq_en` bit is clear never drives `irq_n` low.
- R8: With `pulse_mode` = 0, `irq_n` is low exactly while some flag whose `alm_irq_en` bit is set is pending. It returns high in the cycle after the clearing read.
- R9: With `pulse_mode` = 1, each match of an interrupt-enabled alarm drives `irq_n` low from the cycle after the tick. The line returns high after exactly PULSE_TICKS `pre_tick` cycles, regardless of the status flags.
- R10: In pulsed mode, a new enabled match while a pulse is running restarts the full pulse width.
- R11: After reset, `stat_flags` is all zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second; comparisons happen only here |
| pre_tick | input | 1 | Prescaler strobe that times the pulse width |
| cur_time | input | 48 | Current BCD calendar, six 8-bit fields, seconds in the low byte |
| alm_val | input | 96 | Alarm values, 48 bits per alarm, alarm 0 in the low half |
| alm_fen | input | 12 | Field participation bits, six per alarm |
| alm_irq_en | input | 2 | Per-alarm interrupt enable |
| pulse_mode | input | 1 | 0 latched single-shot interrupt, 1 pulsed repeating interrupt |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| stat_flags | output | 2 | Per-alarm match flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with two alarms, six fields and PULSE_TICKS set to 4. The short pulse width lets it count every prescaler tick up to the release edge of a pulse. It can also restart a pulse part way through and measure the renewed full width. The two alarm sets make it possible to set both flags, then collide a clearing read with a match of only one alarm, and observe that exactly that flag survives. Matches with disabled fields, with no enabled fields, and with no tick are all checked at the flag outputs.

// File: rtl/alm_pkg.sv
package alm_pkg;

  // A match needs at least one participating field, and every participating
  // field must compare equal.
  function automatic logic fields_hit(input logic [5:0] eq, input logic [5:0] fen);
    logic all_ok;
    all_ok = 1'b1;
    for (int f = 0; f < 6; f++) begin
      if (fen[f] && !eq[f]) all_ok = 1'b0;
    end
    return all_ok && (fen != '0);
  endfunction

  // Next value of the pulse-width down-counter; a new trigger reloads it.
  function automatic int unsigned pulse_next(input int unsigned cur,
                                             input logic trig,
                                             input logic step,
                                             input int unsigned width);
    if (trig) return width;
    if (step && cur != 0) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/alm_cmp.sv
module alm_cmp #(
  parameter int NUM_FLD = 6,
  parameter int FLD_W   = 8
) (
  input  logic [NUM_FLD*FLD_W-1:0] cur_time,
  input  logic [NUM_FLD*FLD_W-1:0] alm_val,
  input  logic [NUM_FLD-1:0]       fen,
  output logic                     hit
);
  import alm_pkg::*;

  logic [5:0] eq_vec;
  logic [5:0] fen_vec;

  // Per-field equality, one comparator per field.
  for (genvar f = 0; f < 6; f++) begin : g_fld
    if (f < NUM_FLD) begin : g_used
      assign eq_vec[f]  = (cur_time[f*FLD_W +: FLD_W] == alm_val[f*FLD_W +: FLD_W]);
      assign fen_vec[f] = fen[f];
    end else begin : g_pad
      assign eq_vec[f]  = 1'b1;
      assign fen_vec[f] = 1'b0;
    end
  end

  assign hit = fields_hit(eq_vec, fen_vec);

endmodule

// File: rtl/alm_flags.sv
module alm_flags #(
  parameter int NUM_ALM = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ALM-1:0] set_ev,
  input  logic               clr_rd,
  output logic [NUM_ALM-1:0] flags
);

  // A set and a clearing read in the same cycle: the set wins.
  for (genvar a = 0; a < NUM_ALM; a++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[a] <= 1'b0;
      else if (set_ev[a]) flags[a] <= 1'b1;
      else if (clr_rd)    flags[a] <= 1'b0;
    end
  end

endmodule

// File: rtl/alm_pulse.sv
module alm_pulse #(
  parameter int PULSE_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic step,
  output logic busy
);
  import alm_pkg::*;

  localparam int CNT_W = $clog2(PULSE_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(pulse_next(int'(cnt_q), trig, step, PULSE_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/alm_match_irq.sv
module alm_match_irq #(
  parameter int NUM_ALM     = 2,
  parameter int NUM_FLD     = 6,
  parameter int FLD_W       = 8,
  parameter int PULSE_TICKS = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sec_tick,
  input  logic                             pre_tick,
  input  logic [NUM_FLD*FLD_W-1:0]         cur_time,
  input  logic [NUM_ALM*NUM_FLD*FLD_W-1:0] alm_val,
  input  logic [NUM_ALM*NUM_FLD-1:0]       alm_fen,
  input  logic [NUM_ALM-1:0]               alm_irq_en,
  input  logic                             pulse_mode,
  input  logic                             stat_rd,
  output logic [NUM_ALM-1:0]               stat_flags,
  output logic                             irq_n
);

  localparam int SET_W = NUM_FLD * FLD_W;

  // Named internal events, brought out for the checker.
  logic [NUM_ALM-1:0] cmp_hit;    // combinational comparison result
  logic [NUM_ALM-1:0] hit_ev;     // match qualified by the second tick
  logic               fire_ev;    // pulsed-mode trigger
  logic               pulse_busy;
  logic               level_req;

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    alm_cmp #(.NUM_FLD(NUM_FLD), .FLD_W(FLD_W)) u_cmp (
      .cur_time (cur_time),
      .alm_val  (alm_val[a*SET_W +: SET_W]),
      .fen      (alm_fen[a*NUM_FLD +: NUM_FLD]),
      .hit      (cmp_hit[a])
    );
  end

  assign hit_ev  = cmp_hit & {NUM_ALM{sec_tick}};
  assign fire_ev = pulse_mode && ((hit_ev & alm_irq_en) != '0);

  alm_flags #(.NUM_ALM(NUM_ALM)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (hit_ev),
    .clr_rd (stat_rd),
    .flags  (stat_flags)
  );

  alm_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (fire_ev),
    .step  (pre_tick),
    .busy  (pulse_busy)
  );

  assign level_req = !pulse_mode && ((stat_flags & alm_irq_en) != '0);
  assign irq_n     = !(level_req || pulse_busy);

endmodule

// File: rtl/alm_match_irq_chk.sv
module alm_match_irq_chk #(
  parameter int NUM_ALM = 2,
  parameter int NUM_FLD = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sec_tick,
  input logic                       stat_rd,
  input logic                       pulse_mode,
  input logic [NUM_ALM*NUM_FLD-1:0] alm_fen,
  input logic [NUM_ALM-1:0]         alm_irq_en,
  input logic [NUM_ALM-1:0]         cmp_hit,
  input logic                       fire_ev,
  input logic [NUM_ALM-1:0]         stat_flags,
  input logic                       irq_n
);

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_chk
    // R3: no participating field, no match
    a_r3_no_field_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_fen[a*NUM_FLD +: NUM_FLD] == '0) |-> !cmp_hit[a]);
  end

  // R4: a flag can only rise after a second tick
  a_r4_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_flags & ~$past(stat_flags)) != '0) |-> $past(sec_tick));

  // R6: flags hold when neither a tick nor a read happens
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !stat_rd) |=> $stable(stat_flags));

  // R6: a read without a tick clears every flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sec_tick) |=> (stat_flags == '0));

  // R8: latched mode keeps the line low while an enabled flag is pending
  a_r8_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && ((stat_flags & alm_irq_en) != '0)) |-> !irq_n);

  // R9: a pulsed trigger pulls the line low in the next cycle
  a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |=> !irq_n);

endmodule

bind alm_match_irq alm_match_irq_chk #(.NUM_ALM(NUM_ALM), .NUM_FLD(NUM_FLD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .stat_rd    (stat_rd),
  .pulse_mode (pulse_mode),
  .alm_fen    (alm_fen),
  .alm_irq_en (alm_irq_en),
  .cmp_hit    (cmp_hit),
  .fire_ev    (fire_ev),
  .stat_flags (stat_flags),
  .irq_n      (irq_n)
);

// File: tb/alm_match_irq_tb.sv
module alm_match_irq_tb;

  localparam int NA = 2;
  localparam int NF = 6;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_tick = 1'b0;
  logic          pre_tick = 1'b0;
  logic [47:0]   cur_time = '0;
  logic [95:0]   alm_val = '0;
  logic [11:0]   alm_fen = '0;
  logic [1:0]    alm_irq_en = '0;
  logic          pulse_mode = 1'b0;
  logic          stat_rd = 1'b0;
  logic [1:0]    stat_flags;
  logic          irq_n;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  alm_match_irq #(.NUM_ALM(NA), .NUM_FLD(NF), .FLD_W(8), .PULSE_TICKS(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pre_tick(pre_tick),
    .cur_time(cur_time), .alm_val(alm_val), .alm_fen(alm_fen),
    .alm_irq_en(alm_irq_en), .pulse_mode(pulse_mode), .stat_rd(stat_rd),
    .stat_flags(stat_flags), .irq_n(irq_n)
  );

  // Calendar: seconds 0x30, minutes 0x45, hours 0x11, date 0x01, month 0x01, dow 0x03
  localparam logic [47:0] T0 = {8'h03, 8'h01, 8'h01, 8'h11, 8'h45, 8'h30};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic strobe_pre();
    @(negedge clk); pre_tick = 1'b1;
    @(negedge clk); pre_tick = 1'b0;
  endtask

  task automatic strobe_rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic set_alm(input int a, input logic [47:0] v, input logic [5:0] fen, input logic ien);
    alm_val[a*48 +: 48] = v;
    alm_fen[a*6 +: 6]   = fen;
    alm_irq_en[a]       = ien;
  endtask

  task automatic t_reset();
    chk("R11 flags", 32'(stat_flags), 0);
    chk("R11 irq_n", 32'(irq_n), 1);
  endtask

  task automatic t_full_match();
    cur_time = T0; pulse_mode = 1'b0;
    set_alm(0, T0, 6'h3f, 1'b1);
    strobe_sec();
    chk("R1 R5 full match flag", 32'(stat_flags), 32'h1);
    chk("R8 latched irq low", 32'(irq_n), 0);
    repeat (5) @(negedge clk);
    chk("R6 flag held", 32'(stat_flags), 32'h1);
    strobe_rd();
    chk("R6 read clears", 32'(stat_flags), 0);
    chk("R8 irq released after read", 32'(irq_n), 1);
  endtask

  task automatic t_mismatch();
    cur_time = T0; cur_time[15:8] = 8'h46;
    strobe_sec();
    chk("R1 minute differs", 32'(stat_flags), 0);
    chk("R1 irq idle", 32'(irq_n), 1);
    cur_time = T0;
  endtask

  task automatic t_partial();
    // Only seconds participate; every other field differs.
    set_alm(0, {8'h07, 8'h12, 8'h31, 8'h23, 8'h59, 8'h30}, 6'h01, 1'b1);
    strobe_sec();
    chk("R2 ignored fields", 32'(stat_flags), 32'h1);
    strobe_rd();
    // Day of week alone, mismatching value in a disabled seconds field
    set_alm(0, {8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h59}, 6'h20, 1'b1);
    strobe_sec();
    chk("R2 dow only", 32'(stat_flags), 32'h1);
    strobe_rd();
  endtask

  task automatic t_no_fields();
    set_alm(0, T0, 6'h00, 1'b1);
    strobe_sec();
    chk("R3 no fields flag", 32'(stat_flags), 0);
    chk("R3 no fields irq", 32'(irq_n), 1);
  endtask

  task automatic t_no_tick();
    set_alm(0, T0, 6'h3f, 1'b1);
    repeat (10) @(negedge clk);
    chk("R4 no tick flag", 32'(stat_flags), 0);
    chk("R4 no tick irq", 32'(irq_n), 1);
  endtask

  task automatic t_irq_disabled();
    set_alm(0, T0, 6'h3f, 1'b0);
    set_alm(1, T0, 6'h07, 1'b0);
    strobe_sec();
    chk("R5 R7 flags without irq", 32'(stat_flags), 32'h3);
    chk("R7 irq stays high", 32'(irq_n), 1);
    strobe_rd();
    chk("R6 both cleared", 32'(stat_flags), 0);
  endtask

  task automatic t_alarm1_level();
    set_alm(0, T0, 6'h3f, 1'b0);
    cur_time = T0; cur_time[7:0] = 8'h31;   // alarm 0 misses on seconds
    set_alm(1, {8'h00, 8'h00, 8'h00, 8'h11, 8'h45, 8'h31}, 6'h07, 1'b1);
    strobe_sec();
    chk("R5 alarm1 only", 32'(stat_flags), 32'h2);
    chk("R8 alarm1 level", 32'(irq_n), 0);
    strobe_rd();
    chk("R8 alarm1 released", 32'(irq_n), 1);
    cur_time = T0;
  endtask

  task automatic t_read_collide();
    set_alm(0, T0, 6'h3f, 1'b0);
    set_alm(1, T0, 6'h3f, 1'b0);
    strobe_sec();
    chk("R5 both set", 32'(stat_flags), 32'h3);
    set_alm(1, T0, 6'h00, 1'b0);
    @(negedge clk); sec_tick = 1'b1; stat_rd = 1'b1;
    @(negedge clk); sec_tick = 1'b0; stat_rd = 1'b0;
    chk("R6 set wins over read", 32'(stat_flags), 32'h1);
    strobe_rd();
  endtask

  task automatic t_pulse();
    pulse_mode = 1'b1;
    set_alm(0, T0, 6'h3f, 1'b1);
    set_alm(1, T0, 6'h00, 1'b0);
    strobe_sec();
    chk("R9 pulse starts", 32'(irq_n), 0);
    for (int i = 0; i < PW - 1; i++) strobe_pre();
    chk("R9 low before last tick", 32'(irq_n), 0);
    strobe_pre();
    chk("R9 released after width", 32'(irq_n), 1);
    chk("R9 flag still pending", 32'(stat_flags), 32'h1);
    strobe_sec();
    chk("R9 repeats on next match", 32'(irq_n), 0);
    for (int i = 0; i < PW - 2; i++) strobe_pre();
    strobe_sec();
    for (int i = 0; i < PW - 1; i++) strobe_pre();
    chk("R10 restarted width", 32'(irq_n), 0);
    strobe_pre();
    chk("R10 released after full width", 32'(irq_n), 1);
    strobe_rd();
    pulse_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_match();
    t_mismatch();
    t_partial();
    t_no_fields();
    t_no_tick();
    t_irq_disabled();
    t_alarm1_level();
    t_read_collide();
    t_pulse();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule